// File: doc/BRIEF.md
# Flash Status Register Protection Unit

This block holds the eight-bit status word of a serial NOR flash and decides, command by command, whether a state-changing request may proceed. A command decoder upstream hands it one decoded operation per cycle: set or clear the write latch, read the status, load the status word, program, erase one sector or erase the whole array. Program and sector-erase requests carry the target byte address. The block also watches the write-protect pin and the completion strobe from the array sequencer.

Each command receives a registered accept or reject answer on the next cycle. The status word, including the write latch and the busy bit, is updated at that same clock edge. A protected window of the array is described by a three-bit block-protect field and a top/bottom bit. Program and erase requests that fall inside the window are refused. A whole-array erase is refused unless the field is zero. The protection-related bits model non-volatile storage: a soft reset leaves them alone, and only the power-on reset clears them.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The status word reads, from bit 7 down, lock bit (L), a spare bit that always reads 0, top/bottom (TB), block-protect field BP[2:0], write latch (WEL) and busy (WIP). After power-on reset all eight bits are 0 and `resp_valid` is 0.
- R2: Every cycle with `cmd_valid` high produces `resp_valid` high one cycle later, and no response appears otherwise. A status read (op 2) is always accepted and changes nothing. The reserved op 7 is rejected and changes nothing.
- R3: While idle, a set-latch command (op 0) is accepted and sets WEL, and a clear-latch command (op 1) is accepted and clears WEL.
- R4: A status load (op 3), program (op 4), sector erase (op 5) or bulk erase (op 6) issued while WEL is 0 is rejected and leaves L, TB and BP unchanged and WIP at 0.
- R5: An accepted status load copies data bits 7, 5 and 4:2 into L, TB and BP, ignores data bits 6, 1 and 0, and sets WIP.
- R6: Hardware lock is in force when L is 1 and `wp_n` is 0. In that state a status load is rejected and L, TB and BP keep their values.
- R7: For BP = n with n in 1..7, the protected window is 64 KiB × 2^(n−1) bytes, capped at the full 4 MiB array. It sits at the highest addresses when TB = 0 and at the lowest when TB = 1. A program or sector erase whose address falls inside the window is rejected. With BP = 0 nothing is protected.
- R8: A bulk erase is accepted only when BP is 000.
- R9: An accepted status load, program or erase sets WIP, and `busy` equals WIP. WIP stays 1 until `op_done` is seen high, and at that edge both WIP and WEL clear.
- R10: Any rejected status load, program or erase clears WEL.
- R11: While WIP is 1, every command except a status read is rejected and leaves L, TB, BP and WEL unchanged.
- R12: Holding `srst_n` low clears WEL, WIP and `resp_valid`, but keeps L, TB and BP. Holding `por_n` low clears all of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears every bit |
| srst_n | input | 1 | Soft reset, active low, clears only the volatile bits |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code: 0 set latch, 1 clear latch, 2 read, 3 load status, 4 program, 5 sector erase, 6 bulk erase, 7 reserved |
| wr_data | input | 8 | New status value for a status load |
| addr | input | 22 | Target byte address for program and sector erase |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion strobe from the array sequencer |
| status | output | 8 | Status word |
| resp_valid | output | 1 | Response to the command of the previous cycle |
| resp_accept | output | 1 | 1 when that command was accepted |
| busy | output | 1 | Copy of WIP |

## Verification
Each command is sampled at one rising edge. Its accept flag and its effect on the status word (latch, busy bit and protection bits) are all due at that same edge, so they are visible one cycle after the command. A completion strobe clears WIP and WEL at the edge that samples it, and a soft reset acts as soon as it is asserted. The bench drives inputs on falling edges and reads results on the next falling edge, half a cycle after the edge that produced them. Each check therefore sees exactly one command's outcome. Protection windows are checked against the bench's own model of window size and placement at the window edges, for every BP value and both TB settings.

// File: rtl/fwp_pkg.sv
package fwp_pkg;

  typedef enum logic [2:0] {
    OP_SETLATCH = 3'd0,
    OP_CLRLATCH = 3'd1,
    OP_READ     = 3'd2,
    OP_LOADSR   = 3'd3,
    OP_PROG     = 3'd4,
    OP_SECERASE = 3'd5,
    OP_BULKERASE= 3'd6,
    OP_RSVD     = 3'd7
  } fwp_op_e;

  // Commands that start an array or status cycle
  function automatic logic is_write_type(input fwp_op_e op);
    return (op == OP_LOADSR) || (op == OP_PROG) ||
           (op == OP_SECERASE) || (op == OP_BULKERASE);
  endfunction

  // log2 of the protected window size in bytes, capped at the array size
  function automatic int region_log2(input logic [2:0] bp, input int unit_log2,
                                     input int addr_w);
    int r;
    r = unit_log2 + int'(bp) - 1;
    if (r > addr_w) r = addr_w;
    return r;
  endfunction

endpackage

// File: rtl/fwp_guard_eval.sv
module fwp_guard_eval
  import fwp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int UNIT_LOG2 = 16
) (
  input  logic              cmd_valid,
  input  fwp_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              wel,
  input  logic              hw_lock,
  input  logic [2:0]        bp,
  input  logic              tb,
  output logic              ev_accept,
  output logic              ev_start,
  output logic              ev_nv_write,
  output logic              ev_set_wel,
  output logic              ev_clr_wel,
  output logic              ev_addr_prot
);

  logic [ADDR_W-1:0] win_mask;
  logic              reject_wr;
  int                win_log2;

  // Window mask: ones on the address bits above the window size
  always_comb begin
    win_log2 = region_log2(bp, UNIT_LOG2, ADDR_W);
    win_mask = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i < win_log2) win_mask[i] = 1'b0;
    end
    if (bp == 3'b000)
      ev_addr_prot = 1'b0;
    else if (tb)
      ev_addr_prot = ((addr & win_mask) == '0);
    else
      ev_addr_prot = ((addr & win_mask) == win_mask);
  end

  always_comb begin
    ev_accept   = 1'b0;
    ev_start    = 1'b0;
    ev_nv_write = 1'b0;
    ev_set_wel  = 1'b0;
    reject_wr   = 1'b0;
    if (cmd_valid) begin
      if (busy) begin
        ev_accept = (op == OP_READ);
      end else begin
        unique case (op)
          OP_SETLATCH: begin ev_accept = 1'b1; ev_set_wel = 1'b1; end
          OP_CLRLATCH: ev_accept = 1'b1;
          OP_READ:     ev_accept = 1'b1;
          OP_LOADSR: begin
            if (wel && !hw_lock) begin
              ev_accept = 1'b1; ev_start = 1'b1; ev_nv_write = 1'b1;
            end else reject_wr = 1'b1;
          end
          OP_PROG, OP_SECERASE: begin
            if (wel && !ev_addr_prot) begin
              ev_accept = 1'b1; ev_start = 1'b1;
            end else reject_wr = 1'b1;
          end
          OP_BULKERASE: begin
            if (wel && (bp == 3'b000)) begin
              ev_accept = 1'b1; ev_start = 1'b1;
            end else reject_wr = 1'b1;
          end
          default: ev_accept = 1'b0;
        endcase
      end
    end
    ev_clr_wel = reject_wr || (cmd_valid && !busy && op == OP_CLRLATCH);
  end

endmodule

// File: rtl/fwp_nv_bank.sv
module fwp_nv_bank (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic       lock_in,
  input  logic       tb_in,
  input  logic [2:0] bp_in,
  output logic       lock_q,
  output logic       tb_q,
  output logic [2:0] bp_q
);

  // Cleared only at power-on; soft reset has no path here
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
      tb_q   <= 1'b0;
      bp_q   <= 3'b000;
    end else if (wr_en) begin
      lock_q <= lock_in;
      tb_q   <= tb_in;
      bp_q   <= bp_in;
    end
  end

endmodule

// File: rtl/fwp_latch_ctrl.sv
module fwp_latch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_wel,
  input  logic clr_wel,
  input  logic start,
  input  logic done,
  output logic wel_q,
  output logic wip_q,
  output logic cycle_end
);

  assign cycle_end = done && wip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= 1'b0;
    end else if (start) begin
      wip_q <= 1'b1;
    end else if (cycle_end) begin
      wip_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
    end else if (cycle_end || clr_wel) begin
      wel_q <= 1'b0;
    end else if (set_wel) begin
      wel_q <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import fwp_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int UNIT_LOG2 = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              srst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status,
  output logic              resp_valid,
  output logic              resp_accept,
  output logic              busy
);

  localparam int LOCK_BIT = 7;
  localparam int TB_BIT   = 5;

  fwp_op_e    op;
  logic       vol_rst_n;
  logic       lock_q, tb_q, wel_q, wip_q;
  logic [2:0] bp_q;
  logic       hw_lock;
  logic       ev_accept, ev_start, ev_nv_write, ev_set_wel, ev_clr_wel;
  logic       ev_addr_prot, ev_cycle_end;
  logic       unused_bits;

  assign op          = fwp_op_e'(cmd_op);
  assign vol_rst_n   = por_n && srst_n;
  assign hw_lock     = lock_q && !wp_n;
  assign unused_bits = ^{wr_data[6], wr_data[1:0], ev_addr_prot, ev_cycle_end};

  fwp_guard_eval #(.ADDR_W(ADDR_W), .UNIT_LOG2(UNIT_LOG2)) u_eval (
    .cmd_valid    (cmd_valid),
    .op           (op),
    .addr         (addr),
    .busy         (wip_q),
    .wel          (wel_q),
    .hw_lock      (hw_lock),
    .bp           (bp_q),
    .tb           (tb_q),
    .ev_accept    (ev_accept),
    .ev_start     (ev_start),
    .ev_nv_write  (ev_nv_write),
    .ev_set_wel   (ev_set_wel),
    .ev_clr_wel   (ev_clr_wel),
    .ev_addr_prot (ev_addr_prot)
  );

  fwp_nv_bank u_nv (
    .clk     (clk),
    .por_n   (por_n),
    .wr_en   (ev_nv_write),
    .lock_in (wr_data[LOCK_BIT]),
    .tb_in   (wr_data[TB_BIT]),
    .bp_in   (wr_data[4:2]),
    .lock_q  (lock_q),
    .tb_q    (tb_q),
    .bp_q    (bp_q)
  );

  fwp_latch_ctrl u_latch (
    .clk       (clk),
    .rst_n     (vol_rst_n),
    .set_wel   (ev_set_wel),
    .clr_wel   (ev_clr_wel),
    .start     (ev_start),
    .done      (op_done),
    .wel_q     (wel_q),
    .wip_q     (wip_q),
    .cycle_end (ev_cycle_end)
  );

  always_ff @(posedge clk or negedge vol_rst_n) begin
    if (!vol_rst_n) begin
      resp_valid  <= 1'b0;
      resp_accept <= 1'b0;
    end else begin
      resp_valid  <= cmd_valid;
      resp_accept <= ev_accept;
    end
  end

  assign status = {lock_q, 1'b0, tb_q, bp_q, wel_q, wip_q};
  assign busy   = wip_q;

endmodule

// File: rtl/fwp_guard_chk.sv
module fwp_guard_chk
  import fwp_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       srst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       op_done,
  input logic [7:0] status,
  input logic       resp_valid,
  input logic       resp_accept,
  input logic       busy,
  input logic       hw_lock
);

  logic wr_cmd_idle;
  assign wr_cmd_idle = cmd_valid && !busy && is_write_type(fwp_op_e'(cmd_op));

  // R2
  resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    cmd_valid |=> resp_valid);

  // R4
  wel_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (wr_cmd_idle && !status[1]) |=> !resp_accept);

  // R6
  hw_lock_freeze_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (cmd_valid && !busy && cmd_op == 3'd3 && hw_lock)
      |=> (!resp_accept && status[7:2] == $past(status[7:2])));

  // R8
  bulk_guard_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (cmd_valid && !busy && cmd_op == 3'd6 && status[4:2] != 3'b000) |=> !resp_accept);

  // R9
  cycle_end_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (op_done && busy) |=> (!busy && !status[1]));

  // R10
  reject_drops_wel_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    wr_cmd_idle |=> (resp_accept || !status[1]));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!por_n || !srst_n)
    (cmd_valid && busy && cmd_op != 3'd2 && !op_done)
      |=> (!resp_accept && status[7:1] == $past(status[7:1])));

  // R12
  soft_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!srst_n && $past(!srst_n)) |-> (status[7:2] == $past(status[7:2]) && !resp_valid));

endmodule

bind flash_wp_ctrl fwp_guard_chk u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .srst_n      (srst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .op_done     (op_done),
  .status      (status),
  .resp_valid  (resp_valid),
  .resp_accept (resp_accept),
  .busy        (busy),
  .hw_lock     (hw_lock)
);

// File: tb/tb_flash_wp_ctrl.sv
`timescale 1ns/1ps
module tb_flash_wp_ctrl;

  localparam int AW  = 22;
  localparam int MEM = 1 << AW;
  localparam int NV  = 27;

  logic          clk = 1'b0;
  logic          por_n = 1'b0, srst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [7:0]    wr_data = '0;
  logic [AW-1:0] addr = '0;
  logic          wp_n = 1'b1, op_done = 1'b0;
  logic [7:0]    status;
  logic          resp_valid, resp_accept, busy;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  flash_wp_ctrl dut (
    .clk(clk), .por_n(por_n), .srst_n(srst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .wr_data(wr_data), .addr(addr), .wp_n(wp_n),
    .op_done(op_done), .status(status), .resp_valid(resp_valid),
    .resp_accept(resp_accept), .busy(busy)
  );

  // Row: {valid, op, data, addr, wp_n, done, exp_accept, exp_status}
  localparam logic [44:0] VEC [NV] = '{
    {1'b1,3'd2,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h00}, //0  R2 read
    {1'b1,3'd4,8'h00,22'h0,     1'b1,1'b0,1'b0,8'h00}, //1  R4 program, latch clear
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h02}, //2  R3 set latch
    {1'b1,3'd1,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h00}, //3  R3 clear latch
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h02}, //4  R3
    {1'b1,3'd3,8'hFF,22'h0,     1'b1,1'b0,1'b1,8'hBF}, //5  R5 R9 load, bit 6 ignored
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b0,8'hBF}, //6  R11 busy
    {1'b0,3'd0,8'h00,22'h0,     1'b1,1'b1,1'b0,8'hBC}, //7  R9 done
    {1'b1,3'd6,8'h00,22'h0,     1'b1,1'b0,1'b0,8'hBC}, //8  R4 bulk, latch clear
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'hBE}, //9
    {1'b1,3'd6,8'h00,22'h0,     1'b1,1'b0,1'b0,8'hBC}, //10 R8 R10 bulk with BP=7
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'hBE}, //11
    {1'b1,3'd3,8'h00,22'h0,     1'b0,1'b0,1'b0,8'hBC}, //12 R6 hardware lock
    {1'b1,3'd0,8'h00,22'h0,     1'b0,1'b0,1'b1,8'hBE}, //13
    {1'b1,3'd3,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h03}, //14 R5 pin high: load ok
    {1'b0,3'd0,8'h00,22'h0,     1'b1,1'b1,1'b0,8'h00}, //15 R9
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h02}, //16
    {1'b1,3'd6,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h03}, //17 R8 bulk with BP=0
    {1'b0,3'd0,8'h00,22'h0,     1'b1,1'b1,1'b0,8'h00}, //18
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h02}, //19
    {1'b1,3'd3,8'h47,22'h0,     1'b1,1'b0,1'b1,8'h07}, //20 R5 bits 6,1,0 ignored
    {1'b0,3'd0,8'h00,22'h0,     1'b1,1'b1,1'b0,8'h04}, //21
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h06}, //22
    {1'b1,3'd4,8'h00,22'h3F0000,1'b1,1'b0,1'b0,8'h04}, //23 R7 R10 top 64 KiB
    {1'b1,3'd0,8'h00,22'h0,     1'b1,1'b0,1'b1,8'h06}, //24
    {1'b1,3'd5,8'h00,22'h3EFFFF,1'b1,1'b0,1'b1,8'h07}, //25 R7 just below window
    {1'b0,3'd0,8'h00,22'h0,     1'b1,1'b1,1'b0,8'h04}  //26
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic [AW-1:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; wr_data = d; addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  // Bench model of the window: size doubles per BP step from 64 KiB
  function automatic bit in_window(input int bp, input bit tb, input int a);
    longint sz;
    if (bp == 0) return 1'b0;
    sz = 64'd65536;
    for (int k = 1; k < bp; k++) sz = sz * 2;
    if (sz > MEM) sz = MEM;
    return tb ? (a < sz) : (longint'(a) >= MEM - sz);
  endfunction

  function automatic int clampa(input longint v);
    if (v < 0) return 0;
    if (v > MEM - 1) return MEM - 1;
    return int'(v);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1; srst_n = 1'b1;
    @(negedge clk);
    // R1 power-on state
    check("R1 status", status, 8'h00);
    check("R1 resp_valid", resp_valid, 0);
    check("R9 busy", busy, 0);

    for (int r = 0; r < NV; r++) begin
      logic [44:0] v;
      v = VEC[r];
      @(negedge clk);
      cmd_valid = v[44]; cmd_op = v[43:41]; wr_data = v[40:33];
      addr = v[32:11]; wp_n = v[10]; op_done = v[9];
      @(negedge clk);
      cmd_valid = 1'b0; op_done = 1'b0;
      check($sformatf("R2 row %0d resp_valid", r), resp_valid, v[44]);
      if (v[44]) check($sformatf("row %0d accept", r), resp_accept, v[8]);
      check($sformatf("row %0d status", r), status, v[7:0]);
      check($sformatf("R9 row %0d busy", r), busy, v[0]);
    end
    wp_n = 1'b1;

    // R2 reserved op: rejected, latch kept
    issue(3'd0, 8'h00, '0);
    issue(3'd7, 8'hFF, '0);
    check("R2 reserved accept", resp_accept, 0);
    check("R2 reserved status", status, 8'h06);
    issue(3'd1, 8'h00, '0);

    // R7 window sweep over BP and TB
    for (int bp = 1; bp < 8; bp++) begin
      for (int tb = 0; tb < 2; tb++) begin
        longint sz;
        int pts [6];
        sz = 64'd65536 << (bp - 1);
        if (sz > MEM) sz = MEM;
        pts = '{0, clampa(sz - 1), clampa(sz), clampa(MEM - sz - 1),
                clampa(MEM - sz), MEM - 1};
        issue(3'd0, 8'h00, '0);
        issue(3'd3, 8'((tb << 5) | (bp << 2)), '0);
        pulse_done();
        check("R5 loaded BP/TB", status, (tb << 5) | (bp << 2));
        for (int p = 0; p < 6; p++) begin
          bit prot;
          prot = in_window(bp, tb[0], pts[p]);
          issue(3'd0, 8'h00, '0);
          issue(3'd4, 8'h00, AW'(pts[p]));
          check($sformatf("R7 bp%0d tb%0d addr %0h", bp, tb, pts[p]),
                resp_accept, prot ? 0 : 1);
          if (!prot) pulse_done();
        end
      end
    end

    // R12 soft reset mid-cycle keeps protection bits
    issue(3'd0, 8'h00, '0);
    issue(3'd3, 8'hAC, '0);
    check("R5 load 0xAC", status, 8'hAF);
    @(negedge clk); srst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 soft reset status", status, 8'hAC);
    check("R12 soft reset busy", busy, 0);
    check("R12 soft reset resp", resp_valid, 0);
    srst_n = 1'b1;

    // R3 latch clear via clear-latch while idle, then R4 program rejected
    issue(3'd0, 8'h00, '0);
    issue(3'd1, 8'h00, '0);
    issue(3'd5, 8'h00, '0);
    check("R4 erase with latch clear", resp_accept, 0);
    check("R4 status unchanged", status, 8'hAC);

    // R12 power-on reset clears everything
    @(negedge clk); por_n = 1'b0;
    @(negedge clk);
    check("R12 por status", status, 8'h00);
    por_n = 1'b1;
    @(negedge clk);
    check("R2 no command no response", resp_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule